// File: doc/BRIEF.md
# Integer Clock Divider with Registered Terminal Clear

The block derives a slow, stable tone or tick from a low-frequency reference clock, such as a 32768 Hz watch crystal. It divides that clock by an integer ratio. A binary counter runs until a decoded terminal value is reached, and the counter then clears. The clear does not come straight from the decode gate. A flip-flop on the falling edge of the reference captures it, and the counter acts on it at the next rising edge. Each clear is therefore one full reference period wide and has no unclocked glitch.

Two output styles are offered, chosen by a static mode pin:

- **Pulse mode** gives one high cycle per divided period. At the default ratio of 20 this is a 5% duty cycle at 1638.4 Hz.
- **Square mode** runs the same counter over half the ratio and follows it with a toggle flip-flop. The result is a symmetric square wave. This suits ratios of the form 10·2^k, and any other even ratio.

The ratio and the mode are static settings. Change them only while reset is held.

Top module: `clkdiv_decoded`

## Requirements
- R1: A ratio value of 0 or 1 behaves exactly as a ratio of 2.
- R2: In pulse mode (mode pin low), the output rises once every N reference clocks, where N is the clamped ratio.
- R3: In pulse mode, every output pulse is exactly one reference clock wide.
- R4: The terminal clear is held for exactly one reference clock. The counter is zero after the rising edge that sees the clear.
- R5: In square mode (mode pin high), with H = floor(N/2), the output period is 2·H clocks and the high time is exactly H clocks. For even N this is a period of N with N/2 high.
- R6: In square mode, an odd ratio N produces a period of N−1 clocks.
- R7: While the synchronous reset is high, the output is low. After any reset cycle, the counter, the clear flip-flop and the toggle stage start from zero.
- R8: At the default ratio of 20, both modes have a period of 20 clocks: the pulse is 1 clock high, and the square wave is 10 clocks high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; the counter uses its rising edge, the clear flip-flop its falling edge |
| rst | input | 1 | Synchronous reset, active high |
| ratio | input | RATIO_W (16) | Static divide ratio N; values below 2 act as 2 |
| square_mode | input | 1 | 0 = one-clock pulse per period, 1 = symmetric square wave |
| div_out | output | 1 | Divided output |

## Verification
Every ratio from 0 to 24 is tried in both modes. This sweep separates these cases:
- the clamp region (0 and 1);
- the degenerate half-ratio of 1, where the toggle flips every clock;
- odd ratios, which expose the floor in square mode;
- even ratios, which must be exactly symmetric.

The default ratio of 20 and the larger ratios 1000 and 4096 show that the counter carries correctly over many bits. Each configuration is measured over two consecutive periods, which separates a correct steady state from a first period that only happens to be right. A reset asserted in the middle of a run checks that the output falls and that counting restarts.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  typedef enum logic {
    OUT_PULSE  = 1'b0,
    OUT_SQUARE = 1'b1
  } out_mode_e;

  localparam int unsigned MIN_RATIO = 2;
endpackage

// File: rtl/clkdiv_term.sv
// Derives the terminal count from the ratio and the output style.
module clkdiv_term
  import clkdiv_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] ratio,
  input  out_mode_e    mode,
  output logic [W-1:0] term
);
  localparam logic [W-1:0] LOW_LIMIT = W'(MIN_RATIO);

  logic [W-1:0] full_n;
  logic [W-1:0] half_n;

  always_comb begin
    // R1: clamp ratios below two
    full_n = (ratio < LOW_LIMIT) ? LOW_LIMIT : ratio;
    half_n = full_n >> 1;
    term   = (mode == OUT_SQUARE) ? (half_n - W'(1)) : (full_n - W'(1));
  end

  always_comb begin
    a_r1_half_nonzero : assert (half_n != '0);
  end
endmodule

// File: rtl/clkdiv_count.sv
// Binary counter on the rising edge. The clear flip-flop on the falling edge
// captures the decoded terminal state.
module clkdiv_count #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] term,
  output logic         clr_q
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)        cnt <= '0;
    else if (clr_q) cnt <= '0;
    else            cnt <= cnt + W'(1);
  end

  // Registered clear: one full clock wide, never straight from the gate
  always_ff @(negedge clk) begin
    if (rst) clr_q <= 1'b0;
    else     clr_q <= (cnt >= term);
  end

  a_r4_restart_zero : assert property (@(posedge clk) disable iff (rst)
    clr_q |=> (cnt == '0));

  a_r4_clear_single : assert property (@(posedge clk) disable iff (rst)
    (clr_q && term != '0 && $stable(term)) |=> !clr_q);

  a_r7_reset_count : assert property (@(posedge clk)
    rst |=> (cnt == '0));
endmodule

// File: rtl/clkdiv_out.sv
// Output stage: a one-cycle pulse register or a toggle flip-flop.
module clkdiv_out
  import clkdiv_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  out_mode_e mode,
  input  logic      clr_q,
  output logic      div_out
);
  logic pulse_q;
  logic tog_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse_q <= 1'b0;
      tog_q   <= 1'b0;
    end else begin
      pulse_q <= clr_q;
      if (clr_q) tog_q <= ~tog_q;
    end
  end

  assign div_out = (mode == OUT_SQUARE) ? tog_q : pulse_q;

  a_r3_pulse_single : assert property (@(posedge clk) disable iff (rst)
    (mode == OUT_PULSE && pulse_q) |=> !pulse_q);

  a_r5_toggle_flip : assert property (@(posedge clk) disable iff (rst)
    clr_q |=> (tog_q != $past(tog_q)));

  a_r7_reset_low : assert property (@(posedge clk)
    rst |=> !div_out);
endmodule

// File: rtl/clkdiv_decoded.sv
module clkdiv_decoded
  import clkdiv_pkg::*;
#(
  parameter int unsigned RATIO_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               square_mode,
  output logic               div_out
);
  out_mode_e          mode;
  logic [RATIO_W-1:0] term;
  logic               clr_q;

  assign mode = out_mode_e'(square_mode);

  clkdiv_term #(.W(RATIO_W)) u_term (
    .ratio (ratio),
    .mode  (mode),
    .term  (term)
  );

  clkdiv_count #(.W(RATIO_W)) u_count (
    .clk   (clk),
    .rst   (rst),
    .term  (term),
    .clr_q (clr_q)
  );

  clkdiv_out u_out (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .clr_q   (clr_q),
    .div_out (div_out)
  );
endmodule

// File: tb/clkdiv_decoded_test.sv
module clkdiv_decoded_test;
  localparam int W = 16;
  localparam int WATCHDOG_CYCLES = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] ratio = 16'd20;
  logic         square_mode = 1'b0;
  logic         div_out;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  clkdiv_decoded #(.RATIO_W(W)) uut (
    .clk         (clk),
    .rst         (rst),
    .ratio       (ratio),
    .square_mode (square_mode),
    .div_out     (div_out)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Inputs change midway between rising and falling edges
  task automatic configure(input int n, input bit sq);
    @(posedge clk); #5;
    rst = 1'b1; ratio = W'(n); square_mode = sq;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R7", "output low in reset", int'(div_out), 0);
    @(posedge clk); #5;
    rst = 1'b0;
  endtask

  // Find a rising edge, then measure the period and the high time
  task automatic measure(input string req, input int exp_per, input int exp_hi);
    bit prev;
    bit cur;
    int per;
    int hi;
    int guard;
    @(negedge clk); prev = div_out;
    guard = 0;
    forever begin
      @(negedge clk); cur = div_out; guard++;
      if (cur && !prev) break;
      prev = cur;
      if (guard > 70000) break;
    end
    per = 1; hi = 1; prev = 1'b1;
    forever begin
      @(negedge clk); cur = div_out;
      if (cur && !prev) break;
      per++;
      if (cur) hi++;
      prev = cur;
      if (per > 70000) break;
    end
    check(req, "period", per, exp_per);
    check(req, "high time", hi, exp_hi);
  endtask

  task automatic run_case(input int n, input bit sq);
    int nc;
    int h;
    string tag;
    nc = (n < 2) ? 2 : n;
    h  = nc / 2;
    configure(n, sq);
    if (!sq) begin
      tag = (n < 2) ? "R1" : (n == 20 ? "R8" : "R2");
      measure(tag, nc, 1);        // R2 period, R3 width
      measure("R3", nc, 1);
    end else begin
      tag = (n < 2) ? "R1" : (n == 20 ? "R8" : ((n % 2) != 0 ? "R6" : "R5"));
      measure(tag, 2 * h, h);
      measure("R5", 2 * h, h);
    end
  endtask

  initial begin
    // R7: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R7", "output low at start", int'(div_out), 0);

    for (int n = 0; n <= 24; n++) begin
      run_case(n, 1'b0);
      run_case(n, 1'b1);
    end
    run_case(20, 1'b0);    // R8 default ratio
    run_case(20, 1'b1);
    run_case(1000, 1'b0);
    run_case(4096, 1'b1);

    // R7: reset in the middle of a square run forces the output low, and counting restarts
    configure(8, 1'b1);
    repeat (6) @(posedge clk);   // output high now
    #5 rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R7", "output low after mid-run reset", int'(div_out), 0);
    @(posedge clk); #5 rst = 1'b0;
    measure("R7", 8, 4);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired: actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule